// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block is the retirement end of an out-of-order core. It holds the in-flight micro-ops in a circular buffer of 32 entries. The entries are grouped in eight blocks of four, and the block is the unit of allocation. Dispatch claims one whole block per cycle and marks which of its four slots carry a micro-op. It also marks which micro-ops close an instruction (end-of-instruction bit). Execution units report completion by entry index and may attach a 4-bit fault code. A branch unit may squash everything younger than a given entry.

Commit reads only the oldest block in a cycle. It releases, oldest first, those entries whose whole instruction flow has completed, and reports them as a slot strobe mask together with the block number. A recorded fault does nothing until its entry is the oldest live one. At that point the controller raises a trap and flushes the buffer. An external interrupt request is latched and held pending. It is taken only at an instruction boundary, never while a multi-micro-op flow is partly retired. When both are ready at once, a fault on the oldest entry wins.

Entry index `i` belongs to block `i/4`, slot `i%4`. Bit `s` of every four-bit mask (`disp_mask`, `disp_eoi`, `cmt_mask`) refers to slot `s` of the named block.

Top module: `rob_commit_ctrl`

## Requirements
- R1: Within the oldest block, a committed slot never has an older live slot left uncommitted. A completed younger entry is held back while any older live entry is still incomplete.
- R2: Commit strobes (`cmt_mask`, block `cmt_grp`) only ever name the oldest block, so one cycle never retires entries of two blocks. A block is freed only after all of its live slots have committed. With all eight blocks allocated, `disp_ready` is low. `disp_grp` names the block the next dispatch fills.
- R3: A flow is the run of consecutive live entries that ends at an entry whose end-of-instruction bit is 1. No entry of a flow commits until every entry of that flow has completed.
- R4: A completed flow longer than one block commits block by block in consecutive cycles. For example, a six-entry flow strobes `4'b1111` in one cycle and `4'b0011` of the next block in the following cycle.
- R5: A pulse on `irq_in` sets a pending request. While a flow is partly retired, the request stays pending, and commit stops after the flow's last entry. The interrupt is taken in a cycle where no flow is open. That cycle shows `trap_valid=1`, `trap_is_irq=1` and `flush_req=1`, with no commit strobes.
- R6: A fault reported with a completion is only recorded. A trap is raised (`trap_valid=1`, `trap_is_irq=0`, `trap_code` = the recorded code, `trap_idx` = the entry) once that entry is the oldest live one. Older entries commit first, and the faulting entry itself never commits.
- R7: `mp_valid` with `mp_idx` removes every entry younger than `mp_idx`, including any recorded faults. Dispatch then resumes at the block after the one holding `mp_idx`. A squashed fault never raises a trap.
- R8: If a fault on the oldest entry and a pending interrupt are both eligible in one cycle, the fault trap is taken and the interrupt stays pending. The interrupt is then taken in the next cycle.
- R9: A trap flushes the buffer in one edge. All entries become invalid, both block pointers return to block 0, and `disp_ready` returns to 1.
- R10: After reset: `disp_ready=1`, `disp_grp=0`, `cmt_mask=0`, `trap_valid=0` and `flush_req=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Allocate one block this cycle |
| disp_mask | input | 4 | Slots of the block that carry a micro-op |
| disp_eoi | input | 4 | End-of-instruction bit per slot |
| disp_ready | output | 1 | A block can be allocated |
| disp_grp | output | 3 | Block index the next allocation fills |
| exe_valid | input | 1 | Completion report |
| exe_idx | input | 5 | Entry index completing |
| exe_fault | input | 1 | The completing entry faulted |
| exe_code | input | 4 | Fault code |
| mp_valid | input | 1 | Squash entries younger than `mp_idx` |
| mp_idx | input | 5 | Mispredicted entry (live, not yet completed) |
| irq_in | input | 1 | Asynchronous interrupt request pulse |
| cmt_mask | output | 4 | Slots of block `cmt_grp` committing this cycle |
| cmt_grp | output | 3 | Oldest block index |
| flush_req | output | 1 | Whole-machine flush |
| trap_valid | output | 1 | Trap raised this cycle |
| trap_is_irq | output | 1 | Trap cause is the interrupt |
| trap_code | output | 4 | Fault code of the trapping entry |
| trap_idx | output | 5 | Entry index at which the trap is taken |

## Verification
Some properties are watched on every cycle. The block count never exceeds eight, and no allocation is accepted while the buffer is full. A flush leaves every entry invalid. A fault trap always points at a completed, faulted entry. A pending interrupt survives every cycle in which it is not taken. An interrupt pending across a fault trap is taken on the very next cycle.

The directed scenarios cover the orderings those properties cannot express. These include out-of-order completion inside a block and flows split across blocks and across cycles. They also include an interrupt arriving in mid-flow, a wrong-path fault removed by a squash, and pointer wrap-around after the buffer fills.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int GRP_SZ = 4;
    localparam int N_GRP  = 8;
    localparam int FC_W   = 4;
    localparam int DEPTH  = GRP_SZ * N_GRP;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int GID_W  = $clog2(N_GRP);
    localparam int SLOT_W = $clog2(GRP_SZ);
    localparam int CNT_W  = GID_W + 1;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [GID_W-1:0]  gid_t;
    typedef logic [GRP_SZ-1:0] slot_vec_t;

    typedef struct packed {
        logic            vld;
        logic            done;
        logic            flt;
        logic            eoi;
        logic [FC_W-1:0] code;
    } rob_ent_t;

    // distance of an entry from the first slot of the oldest block
    function automatic idx_t age_of(idx_t idx, gid_t head);
        return idx - idx_t'({head, {SLOT_W{1'b0}}});
    endfunction

    // entry index sitting at a given age
    function automatic idx_t idx_at(gid_t head, idx_t age);
        return idx_t'({head, {SLOT_W{1'b0}}}) + age;
    endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs import rob_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             alloc_i,
    input  logic             adv_i,
    input  logic             sq_i,
    input  gid_t             sq_gage_i,
    output gid_t             head_o,
    output gid_t             tail_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o
);
    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            head_o <= '0;
            tail_o <= '0;
            cnt_o  <= '0;
        end else begin
            head_o <= head_o + gid_t'(adv_i);
            if (sq_i) begin
                tail_o <= head_o + sq_gage_i + gid_t'(1);
                cnt_o  <= CNT_W'(sq_gage_i) + CNT_W'(1) - CNT_W'(adv_i);
            end else begin
                tail_o <= tail_o + gid_t'(alloc_i);
                cnt_o  <= cnt_o + CNT_W'(alloc_i) - CNT_W'(adv_i);
            end
        end
    end

    assign full_o = (cnt_o == CNT_W'(N_GRP));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= CNT_W'(N_GRP));

    // R2
    full_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == CNT_W'(N_GRP)) |-> !alloc_i);
endmodule

// File: rtl/rob_store.sv
module rob_store import rob_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush_i,
    input  logic                  alloc_i,
    input  gid_t                  alloc_grp_i,
    input  slot_vec_t             alloc_mask_i,
    input  slot_vec_t             alloc_eoi_i,
    input  logic                  exe_valid_i,
    input  idx_t                  exe_idx_i,
    input  logic                  exe_fault_i,
    input  logic [FC_W-1:0]       exe_code_i,
    input  logic                  sq_i,
    input  idx_t                  sq_idx_i,
    input  gid_t                  head_i,
    input  slot_vec_t             cmt_i,
    output rob_ent_t [DEPTH-1:0]  ents_o
);
    rob_ent_t ent_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam gid_t EG = gid_t'(e / GRP_SZ);
        localparam int   ES = e % GRP_SZ;
        localparam idx_t EI = idx_t'(e);

        always_ff @(posedge clk) begin
            if (rst || flush_i) begin
                ent_q[e] <= '0;
            end else if (alloc_i && alloc_grp_i == EG) begin
                ent_q[e].vld  <= alloc_mask_i[ES];
                ent_q[e].done <= 1'b0;
                ent_q[e].flt  <= 1'b0;
                ent_q[e].eoi  <= alloc_eoi_i[ES];
                ent_q[e].code <= '0;
            end else begin
                if (exe_valid_i && exe_idx_i == EI && ent_q[e].vld) begin
                    ent_q[e].done <= 1'b1;
                    ent_q[e].flt  <= exe_fault_i;
                    ent_q[e].code <= exe_code_i;
                end
                if (head_i == EG && cmt_i[ES])
                    ent_q[e].vld <= 1'b0;
                if (sq_i && (age_of(EI, head_i) > age_of(sq_idx_i, head_i)))
                    ent_q[e].vld <= 1'b0;
            end
        end

        assign ents_o[e] = ent_q[e];

        // R9
        flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
            flush_i |=> !ent_q[e].vld);
    end
endmodule

// File: rtl/rob_retire.sv
module rob_retire import rob_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  rob_ent_t [DEPTH-1:0] ents_i,
    input  gid_t                 head_i,
    input  logic [CNT_W-1:0]     cnt_i,
    input  logic                 irq_i,
    output slot_vec_t            cmt_o,
    output logic                 adv_o,
    output logic                 trap_o,
    output logic                 trap_irq_o,
    output logic [FC_W-1:0]      trap_code_o,
    output idx_t                 trap_idx_o
);
    logic      irq_pend_q, flow_open_q, flow_n;
    logic      fault_trap, irq_take, all_clear;
    slot_vec_t head_fd, cm;

    always_comb begin
        rob_ent_t ent;
        logic     chain, stop, seen;
        head_fd     = '0;
        chain       = 1'b0;
        for (int a = DEPTH - 1; a >= 0; a--) begin
            ent = ents_i[idx_at(head_i, idx_t'(a))];
            if (ent.vld) chain = ent.done && (ent.eoi || chain);
            if (a < GRP_SZ) head_fd[SLOT_W'(a)] = chain;
        end

        cm          = '0;
        stop        = 1'b0;
        seen        = 1'b0;
        fault_trap  = 1'b0;
        trap_code_o = '0;
        trap_idx_o  = idx_at(head_i, '0);
        for (int s = 0; s < GRP_SZ; s++) begin
            ent = ents_i[idx_at(head_i, idx_t'(s))];
            if (!stop && ent.vld) begin
                if (ent.done && !ent.flt && head_fd[s]) begin
                    cm[s] = 1'b1;
                    if (ent.eoi && irq_pend_q) stop = 1'b1;
                end else begin
                    stop = 1'b1;
                    if (ent.done && ent.flt && !seen) begin
                        fault_trap  = 1'b1;
                        trap_code_o = ent.code;
                        trap_idx_o  = idx_at(head_i, idx_t'(s));
                    end
                end
                seen = 1'b1;
            end
        end

        irq_take   = irq_pend_q && !flow_open_q && !fault_trap;
        trap_o     = fault_trap || irq_take;
        trap_irq_o = irq_take;
        cmt_o      = trap_o ? '0 : cm;

        all_clear = 1'b1;
        flow_n    = flow_open_q;
        for (int s = 0; s < GRP_SZ; s++) begin
            ent = ents_i[idx_at(head_i, idx_t'(s))];
            if (ent.vld && !cmt_o[s]) all_clear = 1'b0;
            if (cmt_o[s]) flow_n = !ent.eoi;
        end
        adv_o = !trap_o && (cnt_i != '0) && all_clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend_q  <= 1'b0;
            flow_open_q <= 1'b0;
        end else begin
            irq_pend_q  <= (irq_pend_q && !irq_take) || irq_i;
            flow_open_q <= trap_o ? 1'b0 : flow_n;
        end
    end

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pend_q && !(trap_o && trap_irq_o)) |=> irq_pend_q);

    // R8
    fault_first_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_o && !trap_irq_o && irq_pend_q) |=> (trap_o && trap_irq_o));

    // R6
    fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_o && !trap_irq_o) |-> (ents_i[trap_idx_o].flt && ents_i[trap_idx_o].done));
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl import rob_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [GRP_SZ-1:0] disp_mask,
    input  logic [GRP_SZ-1:0] disp_eoi,
    output logic              disp_ready,
    output logic [GID_W-1:0]  disp_grp,
    input  logic              exe_valid,
    input  logic [IDX_W-1:0]  exe_idx,
    input  logic              exe_fault,
    input  logic [FC_W-1:0]   exe_code,
    input  logic              mp_valid,
    input  logic [IDX_W-1:0]  mp_idx,
    input  logic              irq_in,
    output logic [GRP_SZ-1:0] cmt_mask,
    output logic [GID_W-1:0]  cmt_grp,
    output logic              flush_req,
    output logic              trap_valid,
    output logic              trap_is_irq,
    output logic [FC_W-1:0]   trap_code,
    output logic [IDX_W-1:0]  trap_idx
);
    gid_t                 head, tail;
    logic [CNT_W-1:0]     cnt;
    logic                 full, alloc, adv;
    rob_ent_t [DEPTH-1:0] ents;
    slot_vec_t            cmt;
    idx_t                 mp_age;

    assign mp_age     = age_of(mp_idx, head);
    assign disp_ready = !full && !mp_valid && !trap_valid;
    assign alloc      = disp_valid && disp_ready;
    assign disp_grp   = tail;
    assign cmt_grp    = head;
    assign cmt_mask   = cmt;
    assign flush_req  = trap_valid;

    rob_ptrs u_ptrs (
        .clk(clk), .rst(rst), .flush_i(trap_valid), .alloc_i(alloc), .adv_i(adv),
        .sq_i(mp_valid), .sq_gage_i(gid_t'(mp_age >> SLOT_W)),
        .head_o(head), .tail_o(tail), .cnt_o(cnt), .full_o(full)
    );

    rob_store u_store (
        .clk(clk), .rst(rst), .flush_i(trap_valid), .alloc_i(alloc), .alloc_grp_i(tail),
        .alloc_mask_i(disp_mask), .alloc_eoi_i(disp_eoi), .exe_valid_i(exe_valid),
        .exe_idx_i(exe_idx), .exe_fault_i(exe_fault), .exe_code_i(exe_code),
        .sq_i(mp_valid), .sq_idx_i(mp_idx), .head_i(head), .cmt_i(cmt), .ents_o(ents)
    );

    rob_retire u_retire (
        .clk(clk), .rst(rst), .ents_i(ents), .head_i(head), .cnt_i(cnt), .irq_i(irq_in),
        .cmt_o(cmt), .adv_o(adv), .trap_o(trap_valid), .trap_irq_o(trap_is_irq),
        .trap_code_o(trap_code), .trap_idx_o(trap_idx)
    );
endmodule

// File: tb/rob_commit_ctrl_tb_top.sv
module rob_commit_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       disp_valid, exe_valid, exe_fault, mp_valid, irq_in;
    logic [3:0] disp_mask, disp_eoi, exe_code;
    logic [4:0] exe_idx, mp_idx;
    logic       disp_ready, flush_req, trap_valid, trap_is_irq;
    logic [2:0] disp_grp, cmt_grp;
    logic [3:0] cmt_mask, trap_code;
    logic [4:0] trap_idx;
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rob_commit_ctrl dut_i (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_mask(disp_mask),
        .disp_eoi(disp_eoi), .disp_ready(disp_ready), .disp_grp(disp_grp),
        .exe_valid(exe_valid), .exe_idx(exe_idx), .exe_fault(exe_fault),
        .exe_code(exe_code), .mp_valid(mp_valid), .mp_idx(mp_idx), .irq_in(irq_in),
        .cmt_mask(cmt_mask), .cmt_grp(cmt_grp), .flush_req(flush_req),
        .trap_valid(trap_valid), .trap_is_irq(trap_is_irq), .trap_code(trap_code),
        .trap_idx(trap_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1; disp_valid = 0; exe_valid = 0; exe_fault = 0; mp_valid = 0;
        irq_in = 0; disp_mask = 0; disp_eoi = 0; exe_code = 0; exe_idx = 0; mp_idx = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
    endtask

    task automatic dispatch(input logic [3:0] m, input logic [3:0] e);
        disp_valid = 1; disp_mask = m; disp_eoi = e;
        @(negedge clk);
        disp_valid = 0;
        #2;
    endtask

    task automatic exe(input int idx, input logic f, input logic [3:0] c);
        exe_valid = 1; exe_idx = 5'(idx); exe_fault = f; exe_code = c;
        @(negedge clk);
        exe_valid = 0; exe_fault = 0;
        #2;
    endtask

    task automatic mispredict(input int idx);
        mp_valid = 1; mp_idx = 5'(idx);
        @(negedge clk);
        mp_valid = 0;
        #2;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 ready", disp_ready, 1);
        chk("R10 grp", disp_grp, 0);
        chk("R10 cmt", cmt_mask, 0);
        chk("R10 trap", trap_valid, 0);
        chk("R10 flush", flush_req, 0);
    endtask

    task automatic t_inorder();
        do_reset();
        dispatch(4'hF, 4'hF);
        chk("R2 tail after one block", disp_grp, 1);
        exe(1, 0, 0);
        chk("R1 younger held", cmt_mask, 0);
        exe(2, 0, 0);
        exe(3, 0, 0);
        chk("R1 younger held", cmt_mask, 0);
        exe(0, 0, 0);
        chk("R1 all commit", cmt_mask, 4'hF);
        chk("R2 commit block", cmt_grp, 0);
        tick();
        chk("R2 block freed", cmt_mask, 0);
    endtask

    task automatic t_flow();
        do_reset();
        dispatch(4'hF, 4'b1010);
        exe(0, 0, 0);
        chk("R3 flow incomplete", cmt_mask, 0);
        exe(1, 0, 0);
        chk("R3 first flow", cmt_mask, 4'b0011);
        exe(3, 0, 0);
        chk("R3 second flow held", cmt_mask, 0);
        exe(2, 0, 0);
        chk("R3 second flow", cmt_mask, 4'b1100);
    endtask

    task automatic t_long();
        do_reset();
        dispatch(4'hF, 4'h0);
        dispatch(4'hF, 4'b1110);
        for (int i = 0; i < 5; i++) exe(i, 0, 0);
        chk("R4 flow not done", cmt_mask, 0);
        exe(5, 0, 0);
        chk("R4 first part", cmt_mask, 4'hF);
        chk("R4 first block", cmt_grp, 0);
        tick();
        chk("R4 second part", cmt_mask, 4'b0011);
        chk("R4 second block", cmt_grp, 1);
        tick();
        chk("R4 rest waits", cmt_mask, 0);
    endtask

    task automatic t_irq();
        do_reset();
        dispatch(4'hF, 4'h0);
        dispatch(4'hF, 4'b1110);
        for (int i = 0; i < 6; i++) exe(i, 0, 0);
        irq_in = 1;
        chk("R5 no trap yet", trap_valid, 0);
        @(negedge clk);
        irq_in = 0;
        #2;
        chk("R5 flow finishes", cmt_mask, 4'b0011);
        chk("R5 deferred", trap_valid, 0);
        tick();
        chk("R5 irq taken", trap_valid, 1);
        chk("R5 irq cause", trap_is_irq, 1);
        chk("R5 flush", flush_req, 1);
        chk("R5 no commit", cmt_mask, 0);
        tick();
        chk("R9 trap over", trap_valid, 0);
        chk("R9 tail reset", disp_grp, 0);
        chk("R9 ready", disp_ready, 1);
        chk("R9 empty", cmt_mask, 0);
    endtask

    task automatic t_fault();
        do_reset();
        dispatch(4'hF, 4'hF);
        exe(1, 1, 4'd9);
        chk("R6 recorded only", trap_valid, 0);
        chk("R6 nothing commits", cmt_mask, 0);
        exe(0, 0, 0);
        chk("R6 older commits", cmt_mask, 4'b0001);
        chk("R6 not oldest yet", trap_valid, 0);
        tick();
        chk("R6 trap", trap_valid, 1);
        chk("R6 cause", trap_is_irq, 0);
        chk("R6 code", trap_code, 9);
        chk("R6 idx", trap_idx, 1);
        chk("R6 fault not committed", cmt_mask, 0);
        tick();
        chk("R9 tail reset", disp_grp, 0);
        chk("R9 ready", disp_ready, 1);
    endtask

    task automatic t_squash();
        do_reset();
        dispatch(4'hF, 4'hF);
        dispatch(4'hF, 4'hF);
        exe(6, 1, 4'd3);
        mispredict(2);
        chk("R7 tail rewound", disp_grp, 1);
        chk("R7 no trap", trap_valid, 0);
        exe(0, 0, 0);
        exe(1, 0, 0);
        exe(2, 0, 0);
        chk("R7 survivor commits", cmt_mask, 4'b0100);
        tick();
        chk("R7 wrong-path fault gone", trap_valid, 0);
        chk("R7 nothing left", cmt_mask, 0);
        chk("R7 tail kept", disp_grp, 1);
    endtask

    task automatic t_prio();
        do_reset();
        dispatch(4'hF, 4'hF);
        irq_in = 1;
        exe(0, 1, 4'd5);
        irq_in = 0;
        chk("R8 fault wins", trap_valid, 1);
        chk("R8 fault cause", trap_is_irq, 0);
        chk("R8 code", trap_code, 5);
        tick();
        chk("R8 irq next", trap_valid, 1);
        chk("R8 irq cause", trap_is_irq, 1);
        tick();
        chk("R8 done", trap_valid, 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int g = 0; g < 8; g++) dispatch(4'b0001, 4'b0001);
        chk("R2 full", disp_ready, 0);
        exe(4, 0, 0);
        chk("R2 non-head waits", cmt_mask, 0);
        exe(0, 0, 0);
        chk("R2 head slot", cmt_mask, 4'b0001);
        chk("R2 head block", cmt_grp, 0);
        tick();
        chk("R2 next block", cmt_mask, 4'b0001);
        chk("R2 next index", cmt_grp, 1);
        chk("R2 space again", disp_ready, 1);
        tick();
        chk("R2 idle", cmt_mask, 0);
        chk("R2 tail wrapped", disp_grp, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_inorder();
        t_flow();
        t_long();
        t_irq();
        t_fault();
        t_squash();
        t_prio();
        t_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule